// File: doc/BRIEF.md
# Up/Down Counter-Timer

This block is a memory-mapped counter-timer with a configurable width (32 bits by default). Software reaches it over a simple synchronous register bus with select, write enable, byte address, write data and registered read data. It has three registers: a control byte, the live count, and a limit value. The limit is the compare point when counting up and the reload point when counting down. Each block drives one interrupt line, so a chip places one instance per timer it needs.

While enabled, the count moves by one on every clock. It starts from whatever the live count holds. Counting up ends when the count equals the limit. Counting down ends when the count reaches zero.

In continuous mode, the end of the count reloads the counter and counting goes on with no idle cycle. In one-shot mode the counter parks on the terminal value. Clearing the enable freezes the count in place. Software can preset or clear the count at any time by writing it.

Top module: `updn_timer`

## Requirements
- R1: The control register is at byte offset 0x0. Its bit 3 enables counting, bit 2 selects one-shot (1) or continuous (0), bit 1 selects up (1) or down (0), and bit 0 enables the interrupt. Bits 7:0 read back as written and bits 31:8 read as zero.
- R2: The live count is at offset 0x4 and the limit at 0x8. Both are CNT_W bits wide, and they are zero-extended on read and truncated on write. Offset 0xC reads zero and ignores writes. A read (select high, write enable low) presents its data on rdata one clock later, and rdata holds its value at all other times.
- R3: While enabled and not parked, the count rises by one (up) or falls by one (down) on every clock, starting from the held count. It wraps modulo 2^CNT_W.
- R4: The terminal condition is count == limit when counting up and count == 0 when counting down.
- R5: In continuous mode, the clock edge at the terminal condition loads 0 (up) or the limit (down). Counting goes on at the next edge, so the period is limit+1 clocks.
- R6: In one-shot mode, the terminal condition parks the counter on its terminal value. The counter leaves the parked state when the count is written or when the enable is cleared. It then counts again once enabled.
- R7: irq is high for exactly the one clock after each terminal event, and only if the interrupt-enable bit was set in the event cycle.
- R8: While the enable is clear, the count does not change except by a bus write.
- R9: A bus write to the count wins over a count step or reload in the same cycle, and that cycle produces no terminal event. Writing zero restarts the timer from zero.
- R10: After reset, all registers, rdata and irq are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus access strobe |
| we | input | 1 | Write (1) or read (0) when sel is high |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Registered read data |
| irq | output | 1 | One-clock terminal-count interrupt pulse |

## Verification
The bench builds the block with CNT_W set to 8, keeping BUS_W at 32 and ADDR_W at 4. The narrow counter puts a full wrap from 255 to 0 within a couple of hundred clocks. It also makes write truncation and zero-extended reads visible on the 32-bit bus. Continuous runs with a limit of 3 give a four-clock interrupt period that is counted over fixed windows. One-shot runs show parking, restart by rewrite and restart by toggling the enable, all in short sequences.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  // control byte field positions (software-visible encoding)
  localparam int CTL_IE_BIT   = 0;
  localparam int CTL_UP_BIT   = 1;
  localparam int CTL_ONCE_BIT = 2;
  localparam int CTL_EN_BIT   = 3;

  // word index = addr[3:2]
  localparam logic [1:0] IDX_CTL   = 2'd0;
  localparam logic [1:0] IDX_COUNT = 2'd1;
  localparam logic [1:0] IDX_LIMIT = 2'd2;

  typedef struct packed {
    logic en;
    logic once;
    logic up;
    logic ie;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [7:0] raw);
    ctl_t c;
    c.en   = raw[CTL_EN_BIT];
    c.once = raw[CTL_ONCE_BIT];
    c.up   = raw[CTL_UP_BIT];
    c.ie   = raw[CTL_IE_BIT];
    return c;
  endfunction

endpackage

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
  import updn_timer_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [CNT_W-1:0]  limit_q,
  output logic              count_wr,
  output logic [CNT_W-1:0]  count_wdata,
  output logic [BUS_W-1:0]  rdata
);

  logic              upper_ok;
  logic [1:0]        idx;
  logic              hit_ctl, hit_count, hit_limit;
  logic [BUS_W-1:0]  ctl_ext, count_ext, limit_ext, rd_word;
  logic              unused_bits;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_ok = ~|addr[ADDR_W-1:4];
    end else begin : g_noupper
      assign upper_ok = 1'b1;
    end

    if (CNT_W < BUS_W) begin : g_ext
      assign count_ext = {{(BUS_W-CNT_W){1'b0}}, count};
      assign limit_ext = {{(BUS_W-CNT_W){1'b0}}, limit_q};
    end else begin : g_full
      assign count_ext = count;
      assign limit_ext = limit_q;
    end
  endgenerate

  assign ctl_ext     = {{(BUS_W-CTL_W){1'b0}}, ctl_q};
  assign idx         = addr[3:2];
  assign hit_ctl     = sel && upper_ok && (idx == IDX_CTL);
  assign hit_count   = sel && upper_ok && (idx == IDX_COUNT);
  assign hit_limit   = sel && upper_ok && (idx == IDX_LIMIT);
  assign count_wr    = hit_count && we;
  assign count_wdata = wdata[CNT_W-1:0];
  assign unused_bits = ^{addr[1:0], wdata};

  always_comb begin
    rd_word = '0;
    if (hit_ctl)   rd_word = ctl_ext;
    if (hit_count) rd_word = count_ext;
    if (hit_limit) rd_word = limit_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      limit_q <= '0;
      rdata   <= '0;
    end else begin
      if (hit_ctl && we)   ctl_q   <= wdata[CTL_W-1:0];
      if (hit_limit && we) limit_q <= wdata[CNT_W-1:0];
      if (sel && !we)      rdata   <= rd_word;
    end
  end

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             once,
  input  logic             up,
  input  logic [CNT_W-1:0] limit,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] count_wdata,
  output logic [CNT_W-1:0] count,
  output logic             parked,
  output logic             tc_event
);

  logic             active, at_term;
  logic [CNT_W-1:0] step_val, reload_val, count_d;
  logic             parked_d;

  assign active     = en && !parked;
  assign at_term    = up ? (count == limit) : (count == '0);
  assign tc_event   = active && at_term && !count_wr;
  assign step_val   = up ? count + 1'b1 : count - 1'b1;
  assign reload_val = up ? '0 : limit;

  always_comb begin
    count_d = count;
    if (count_wr)             count_d = count_wdata;
    else if (active && !at_term) count_d = step_val;
    else if (active && !once)    count_d = reload_val;
  end

  always_comb begin
    parked_d = parked;
    if (count_wr || !en)        parked_d = 1'b0;
    else if (tc_event && once)  parked_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      parked <= 1'b0;
    end else begin
      count  <= count_d;
      parked <= parked_d;
    end
  end

endmodule

// File: rtl/updn_timer_irq.sv
module updn_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic tc_event,
  input  logic ie,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= tc_event && ie;
  end

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);

  localparam int CTL_W = 8;

  logic [CTL_W-1:0] ctl_raw;
  logic [CNT_W-1:0] limit_q, count_q, count_wdata;
  logic             count_wr, parked_q, tc_event;
  ctl_t             ctl;
  logic             ctl_en, ctl_once, ctl_up, ctl_ie;

  assign ctl      = unpack_ctl(ctl_raw);
  assign ctl_en   = ctl.en;
  assign ctl_once = ctl.once;
  assign ctl_up   = ctl.up;
  assign ctl_ie   = ctl.ie;

  updn_timer_regs #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTL_W(CTL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .count(count_q), .ctl_q(ctl_raw), .limit_q(limit_q),
    .count_wr(count_wr), .count_wdata(count_wdata), .rdata(rdata)
  );

  updn_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(ctl_en), .once(ctl_once), .up(ctl_up),
    .limit(limit_q), .count_wr(count_wr), .count_wdata(count_wdata),
    .count(count_q), .parked(parked_q), .tc_event(tc_event)
  );

  updn_timer_irq u_irq (
    .clk(clk), .rst(rst), .tc_event(tc_event), .ie(ctl_ie), .irq(irq)
  );

endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             once,
  input logic             up,
  input logic             ie,
  input logic             parked,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input logic             count_wr,
  input logic [CNT_W-1:0] count_wdata,
  input logic             irq
);

  assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !parked && up && count != limit && !count_wr)
    |=> count == CNT_W'($past(count) + 1'b1));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !parked && !up && count != '0 && !count_wr)
    |=> count == CNT_W'($past(count) - 1'b1));

  assert_reload_up_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !parked && up && !once && count == limit && !count_wr)
    |=> count == '0);

  assert_reload_down_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !parked && !up && !once && count == '0 && !count_wr)
    |=> count == $past(limit));

  assert_park_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !parked && once && !count_wr &&
     (up ? (count == limit) : (count == '0)))
    |=> parked && $stable(count));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !count_wr) |=> $stable(count));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    count_wr |=> count == $past(count_wdata));

endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(ctl_en), .once(ctl_once), .up(ctl_up),
  .ie(ctl_ie), .parked(parked_q), .count(count_q), .limit(limit_q),
  .count_wr(count_wr), .count_wdata(count_wdata), .irq(irq)
);

// File: tb/updn_timer_bench.sv
`timescale 1ns/1ps
module updn_timer_bench;

  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int    n_checks = 0;
  int    n_fail = 0;
  int    irq_seen = 0;
  bit    finished = 1'b0;
  string cur_tag = "R10";

  // behavioural model state
  int unsigned m_ctl = 0, m_cnt = 0, m_lim = 0, m_rd = 0;
  bit          m_park = 0, m_irq = 0;

  always #4 clk = ~clk;

  updn_timer #(.BUS_W(32), .ADDR_W(4), .CNT_W(W)) u_updn_timer (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 0; m_cnt = 0; m_lim = 0; m_rd = 0; m_park = 0; m_irq = 0;
    end else begin
      int  idx;
      bit  en, once, up, ie, vw, act, hit, ev;
      idx  = int'(addr[3:2]);
      en   = m_ctl[3]; once = m_ctl[2]; up = m_ctl[1]; ie = m_ctl[0];
      vw   = sel && we && idx == 1;
      act  = en && !m_park;
      hit  = up ? (m_cnt == m_lim) : (m_cnt == 0);
      ev   = act && hit && !vw;
      if (sel && !we)
        m_rd = (idx == 0) ? m_ctl : (idx == 1) ? m_cnt : (idx == 2) ? m_lim : 0;
      m_irq = ev && ie;
      if (vw || !en) m_park = 0;
      else if (ev && once) m_park = 1;
      if (vw) m_cnt = wdata & MASK;
      else if (act && !hit) m_cnt = (up ? m_cnt + 1 : m_cnt - 1) & MASK;
      else if (act && !once) m_cnt = up ? 0 : m_lim;
      if (sel && we && idx == 0) m_ctl = wdata & 32'hFF;
      if (sel && we && idx == 2) m_lim = wdata & MASK;
    end
  end

  task automatic check(input string tag, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_tag, irq, m_irq);
      check(cur_tag, rdata, m_rd);
      if (irq) irq_seen++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(negedge clk); sel = 0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, v2;
    int base;
    repeat (3) @(negedge clk);
    check("R10", irq, 0);
    check("R10", rdata, 0);
    rst = 0;
    for (int a = 0; a < 12; a += 4) begin
      rd(4'(a), v); check("R10", v, 0);
    end

    cur_tag = "R1";
    wr(4'h0, 32'hFFFF_FF56);
    rd(4'h0, v); check("R1", v, 32'h56);

    cur_tag = "R2";
    wr(4'h8, 32'h1234_56C3);
    rd(4'h8, v); check("R2", v, 32'hC3);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); check("R2", v, 0);

    cur_tag = "R5";  // up continuous, limit 3
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd3);
    wr(4'h4, 32'd0);
    wr(4'h0, 32'h0B);
    idle(8);
    base = irq_seen; idle(16);
    check("R5", irq_seen - base, 4);

    cur_tag = "R8";
    wr(4'h0, 32'h02);
    rd(4'h4, v); idle(5); rd(4'h4, v2);
    check("R8", v2, v);

    cur_tag = "R9";
    wr(4'h0, 32'h0B);
    idle(2);
    wr(4'h4, 32'h80);
    rd(4'h4, v); check("R9", v, 32'h81);

    cur_tag = "R3";  // wraps through 255 -> 0 then reaches limit
    idle(140);
    base = irq_seen; idle(16);
    check("R3", irq_seen - base, 4);

    cur_tag = "R4";  // down continuous: reload to limit
    wr(4'h0, 32'h09);
    idle(8);
    base = irq_seen; idle(16);
    check("R4", irq_seen - base, 4);

    cur_tag = "R6";  // one-shot up to 10
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd10);
    wr(4'h4, 32'd0);
    base = irq_seen;
    wr(4'h0, 32'h0F);
    idle(20);
    check("R6", irq_seen - base, 1);
    rd(4'h4, v); check("R6", v, 10);
    idle(5);
    rd(4'h4, v); check("R6", v, 10);
    base = irq_seen;
    wr(4'h4, 32'd5);
    idle(12);
    check("R6", irq_seen - base, 1);

    cur_tag = "R7";  // one-shot down, interrupt disabled
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd6);
    base = irq_seen;
    wr(4'h0, 32'h0C);
    idle(12);
    check("R7", irq_seen - base, 0);
    rd(4'h4, v); check("R4", v, 0);

    cur_tag = "R6";  // restart by toggling enable
    wr(4'h0, 32'h04);
    wr(4'h4, 32'd3);
    base = irq_seen;
    wr(4'h0, 32'h0D);
    idle(10);
    check("R6", irq_seen - base, 1);
    rd(4'h4, v); check("R6", v, 0);

    cur_tag = "R9";  // writing zero clears count
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd0);
    rd(4'h4, v); check("R9", v, 0);

    idle(2);
    finish_up();
  end

endmodule